// File: doc/BRIEF.md
# Sampling Converter Serial Port Model

This block is a synthesizable stand-in for the digital side of an 18-bit successive-approximation converter. It lets a host-side serial reader be checked without any analog model. A test environment feeds it an 18-bit result value. The host drives a convert strobe, a serial clock and a serial data input. The block answers on a serial data output that has its own output-enable, so it can be tri-stated. All inputs are sampled on the system clock, and every edge of the convert strobe and the serial clock is found by comparing against the previous sample.

A rising convert edge latches the result value and starts a conversion of fixed length. At that same edge, the level on the serial data input chooses between two modes. In select mode the device drives the line only while the convert line is low. In chain mode the serial input feeds the shift register, so several devices can be read back through one line.

An optional start bit, chosen by a static configuration input, warns the host that data is ready. In chain mode this start bit waits until the upstream device signals, by raising the serial input, that it has finished.

Top module: `sar_serial_port`

## Requirements
- R1: The result value is captured at the clock edge that sees the convert rise. Changes on `sample_i` after that edge do not alter the bits shifted out.
- R2: At a convert rise, a high `sdi_i` selects select mode and a low `sdi_i` selects chain mode.
- R3: In select mode the output is disabled from the convert edge to the end of conversion. After that it is enabled only while `cnv_i` is low, and it is disabled again whenever `cnv_i` is high.
- R4: A conversion lasts `CONV_CYCLES` clock cycles, 40 by default. The first result bit appears on `sdo_o` on the `CONV_CYCLES`-th clock edge after the edge that saw the convert rise.
- R5: The 18 result bits leave MSB first. Each falling edge of `sck_i` seen after conversion advances `sdo_o` by one bit.
- R6: While a conversion is running, serial clock falls and further convert rises have no effect.
- R7: In chain mode the output is enabled from the convert edge on and drives 0 during conversion. On each serial clock fall, `sdi_i` enters the low end of the register. After 18 falls, the upstream bits appear on `sdo_o` in the order they were received.
- R8: If `busy_en_i` is high at the convert edge, a start bit of value 1 comes before the MSB, so 19 bits are sent.
- R9: In chain mode with the start bit enabled, `sdo_o` stays 0 after conversion until `sdi_i` is seen high. Serial clock falls during that wait are ignored.
- R10: After reset the output is disabled, `sdo_o` is 0 and no conversion is running.
- R11: Codes are 18-bit two's complement and are passed unchanged. The full-scale positive value 0x1FFFF and the full-scale negative value 0x20000 come out bit-exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_i | input | 1 | Convert strobe; also the select line in select mode |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data input: mode choice and chain data |
| busy_en_i | input | 1 | Static option: send a leading start bit |
| sample_i | input | 18 | Result value supplied by the test environment |
| sdo_o | output | 1 | Serial data output |
| sdo_en_o | output | 1 | Output enable; low means high impedance |

## Verification
The convert rise is seen at the first clock edge after it is driven. The output switches on `CONV_CYCLES` edges later, so the bench checks for "still off" one negative edge before that point and for the first bit exactly at it. Each serial clock fall moves the output one edge after the fall is driven, and each readout bit is sampled at the negative edge that follows. A behavioural model with a bit queue advances on the same clock edges as the design. Every negative edge compares the enable and, while enabled, the data bit, so the start-bit hold and chain forwarding are checked in the very cycle they change.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_DATA = 2'd2
    } port_state_e;

    typedef enum logic {
        MODE_CHAIN  = 1'b0,
        MODE_SELECT = 1'b1
    } port_mode_e;

endpackage

// File: rtl/sar_edge_detect.sv
module sar_edge_detect #(
    parameter int unsigned  W       = 2,
    parameter logic [W-1:0] RISING  = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] edge_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (RISING[i]) begin : g_rise
            assign edge_o[i] = lvl_i[i] & ~prev_q[i];
        end else begin : g_fall
            assign edge_o[i] = ~lvl_i[i] & prev_q[i];
        end
    end
endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
    parameter int unsigned CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);
    localparam int unsigned CW   = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start_i) begin
            t_d.run = 1'b1;
            t_d.cnt = '0;
        end else if (t_q.run) begin
            if (t_q.cnt == LAST) t_d.run = 1'b0;
            else                 t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign done_o = t_q.run && (t_q.cnt == LAST);

    // R4: the counter never passes the programmed length
    a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.run |-> (t_q.cnt <= LAST));

    // R4: a finished conversion stops unless restarted
    a_r4_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !t_q.run);
endmodule

// File: rtl/sar_out_shift.sv
module sar_out_shift #(
    parameter int unsigned DW = 18
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic [DW:0] load_val_i,
    input  logic        shift_i,
    input  logic        ser_i,
    output logic [DW:0] q_o
);
    logic [DW:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i)       sh_d = load_val_i;
        else if (shift_i) sh_d = {sh_q[DW-1:0], ser_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q;

    // R7: a shift moves every bit up one place and takes the serial input at the bottom
    a_r7_shift_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> (q_o[0] == $past(ser_i)) && (q_o[DW:1] == $past(q_o[DW-1:0])));
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port #(
    parameter int unsigned DW          = 18,
    parameter int unsigned CONV_CYCLES = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnv_i,
    input  logic          sck_i,
    input  logic          sdi_i,
    input  logic          busy_en_i,
    input  logic [DW-1:0] sample_i,
    output logic          sdo_o,
    output logic          sdo_en_o
);
    import sar_port_pkg::*;

    typedef struct packed {
        port_state_e   st;
        port_mode_e    mode;
        logic          busy;
        logic          hold;
        logic [DW-1:0] smp;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [1:0]  edges;
    logic        cnv_rise, sck_fall;
    logic        conv_start, conv_done;
    logic        sh_load, sh_shift, sh_ser;
    logic [DW:0] sh_val, sh_q;

    // bit 1: convert line, rising; bit 0: serial clock, falling
    sar_edge_detect #(.W(2), .RISING(2'b10)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({cnv_i, sck_i}),
        .edge_o (edges)
    );
    assign cnv_rise = edges[1];
    assign sck_fall = edges[0];

    sar_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (conv_start),
        .done_o  (conv_done)
    );

    sar_out_shift #(.DW(DW)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sh_load),
        .load_val_i (sh_val),
        .shift_i    (sh_shift),
        .ser_i      (sh_ser),
        .q_o        (sh_q)
    );

    always_comb begin
        c_d        = c_q;
        conv_start = 1'b0;
        sh_load    = 1'b0;
        sh_shift   = 1'b0;
        case (c_q.st)
            ST_CONV: begin
                if (conv_done) begin
                    c_d.st   = ST_DATA;
                    sh_load  = 1'b1;
                    c_d.hold = c_q.busy && (c_q.mode == MODE_CHAIN);
                end
            end
            default: begin
                if (cnv_rise) begin
                    c_d.st     = ST_CONV;
                    c_d.mode   = sdi_i ? MODE_SELECT : MODE_CHAIN;
                    c_d.busy   = busy_en_i;
                    c_d.hold   = 1'b0;
                    c_d.smp    = sample_i;
                    conv_start = 1'b1;
                end else if (c_q.st == ST_DATA) begin
                    if (c_q.hold) begin
                        if (sdi_i) c_d.hold = 1'b0;
                    end else if (sck_fall) begin
                        sh_shift = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, mode: MODE_CHAIN, busy: 1'b0, hold: 1'b0, smp: '0};
        else        c_q <= c_d;
    end

    assign sh_val = {c_q.busy, c_q.smp};
    assign sh_ser = (c_q.mode == MODE_CHAIN) ? sdi_i : 1'b0;

    always_comb begin
        if (c_q.mode == MODE_SELECT) sdo_en_o = (c_q.st == ST_DATA) && !cnv_i;
        else                         sdo_en_o = (c_q.st != ST_IDLE);
        if ((c_q.st == ST_DATA) && !c_q.hold) sdo_o = c_q.busy ? sh_q[DW] : sh_q[DW-1];
        else                                  sdo_o = 1'b0;
    end

    // R3: no drive in select mode while converting
    a_r3_hiz_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == ST_CONV) && (c_q.mode == MODE_SELECT)) |-> !sdo_en_o);

    // R2: mode follows the serial input level seen at the accepted convert edge
    a_r2_mode_pick: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st != ST_CONV) && cnv_rise) |=> ((c_q.mode == MODE_SELECT) == $past(sdi_i)));

    // R6: register contents frozen while a conversion runs
    a_r6_frozen_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == ST_CONV) && !conv_done) |=> ($stable(sh_q) && (c_q.st == ST_CONV)));

    // R1: latched value held through the conversion
    a_r1_sample_held: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_CONV) |=> $stable(c_q.smp));

    // R7: chain mode drives from the convert edge onward
    a_r7_chain_drives: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.mode == MODE_CHAIN) && (c_q.st != ST_IDLE)) |-> sdo_en_o);

    // R9: line kept low while waiting for the upstream device
    a_r9_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == ST_DATA) && c_q.hold) |-> !sdo_o);

    // R10: idle means no drive
    a_r10_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_IDLE) |-> (!sdo_en_o && !sdo_o));
endmodule

// File: tb/sar_serial_port_test.sv
`timescale 1ns/1ps
module sar_serial_port_test;
    localparam int L  = 40;
    localparam int DW = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnv = 1'b0, sck = 1'b0, sdi = 1'b0, busy_cfg = 1'b0;
    logic [DW-1:0] sample = '0;
    logic sdo, sdo_en;

    int n_run = 0, n_fail = 0, cyc = 0;
    string cur_req = "R10";
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    sar_serial_port #(.DW(DW), .CONV_CYCLES(L)) uut (
        .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sck_i(sck), .sdi_i(sdi),
        .busy_en_i(busy_cfg), .sample_i(sample), .sdo_o(sdo), .sdo_en_o(sdo_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // behavioural reference: state 0 idle, 1 converting, 2 data
    int ms = 0, mcnt = 0;
    bit msel = 0, mbusy = 0, mwait = 0, pc = 0, ps = 0;
    logic [DW-1:0] msmp = '0;
    bit mq[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms = 0; mcnt = 0; msel = 0; mbusy = 0; mwait = 0; pc = 0; ps = 0;
            mq.delete();
        end else begin
            bit rise, fall;
            rise = cnv && !pc;
            fall = !sck && ps;
            if (ms == 1) begin
                if (mcnt == L - 1) begin
                    ms = 2;
                    mq.delete();
                    if (mbusy) mq.push_back(1'b1);
                    for (int i = DW - 1; i >= 0; i--) mq.push_back(msmp[i]);
                    mwait = mbusy && !msel;
                end else mcnt++;
            end else if (rise) begin
                ms = 1; mcnt = 0; msel = sdi; mbusy = busy_cfg; msmp = sample; mwait = 0;
            end else if (ms == 2) begin
                if (mwait) begin
                    if (sdi) mwait = 0;
                end else if (fall) begin
                    void'(mq.pop_front());
                    mq.push_back(msel ? 1'b0 : sdi);
                end
            end
            pc = cnv; ps = sck;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            bit exp_en, exp_sdo;
            exp_en  = msel ? (ms == 2 && !cnv) : (ms != 0);
            exp_sdo = (ms == 2 && !mwait && mq.size() > 0) ? mq[0] : 1'b0;
            chk(sdo_en === exp_en, cur_req, "model sdo_en", sdo_en, exp_en);
            if (exp_en) chk(sdo === exp_sdo, cur_req, "model sdo", sdo, exp_sdo);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done_flag) begin
            done_flag = 1'b1;
            chk(1'b0, "WDOG", "watchdog expired", cyc, 150000);
            report();
        end
    end

    task automatic fall_once(input logic d);
        @(negedge clk); #1 sck = 1'b1;
        @(negedge clk); #1 sck = 1'b0; sdi = d;
        @(negedge clk);
    endtask

    task automatic start_conv(input logic sel, input logic bz, input logic [DW-1:0] val,
                              input bit lower_early);
        @(negedge clk); #1 sdi = sel; busy_cfg = bz; sample = val; cnv = 1'b1;
        @(negedge clk); #1 if (lower_early) cnv = 1'b0;
        repeat (L + 1) @(negedge clk);
        #1 if (lower_early) cnv = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_bits(input int n, input logic [DW-1:0] fwd, output logic [39:0] w);
        w = '0;
        for (int i = 0; i < n; i++) begin
            w = {w[38:0], sdo};
            fall_once((i < DW) ? fwd[DW-1-i] : 1'b0);
        end
    endtask

    initial begin
        logic [39:0] w;
        repeat (3) @(negedge clk);
        chk(sdo_en === 1'b0, "R10", "reset sdo_en", sdo_en, 0);
        chk(sdo === 1'b0, "R10", "reset sdo", sdo, 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(sdo_en === 1'b0, "R10", "idle sdo_en", sdo_en, 0);

        // R4/R6/R1/R3: select mode with exact timing and conversion-time disturbances
        cur_req = "R4";
        @(negedge clk); #1 sdi = 1'b1; busy_cfg = 1'b0; sample = 18'h2A5C3; cnv = 1'b1;
        for (int k = 1; k <= L + 1; k++) begin
            @(negedge clk);
            if (k == L)     chk(sdo_en === 1'b0, "R4", "enable one cycle early", sdo_en, 0);
            if (k == L + 1) begin
                chk(sdo_en === 1'b1, "R4", "enable at completion", sdo_en, 1);
                chk(sdo === 1'b1, "R4", "MSB at completion", sdo, 1);
            end
            #1;
            if (k == 1) begin cnv = 1'b0; sample = 18'h15A3C; end
            if (k == 3) sck = 1'b1;
            if (k == 5) sck = 1'b0;
            if (k == 7) cnv = 1'b1;
            if (k == 9) cnv = 1'b0;
        end
        cur_req = "R5";
        read_bits(DW, '0, w);
        chk(w[17:0] === 18'h2A5C3, "R1", "select word (R5 R6)", w[17:0], 18'h2A5C3);

        // R3: convert held high after conversion keeps the line off
        cur_req = "R3";
        start_conv(1'b1, 1'b0, 18'h0F0F0, 1'b0);
        chk(sdo_en === 1'b0, "R3", "high select line keeps off", sdo_en, 0);
        @(negedge clk); #1 cnv = 1'b0;
        @(negedge clk);
        chk(sdo_en === 1'b1, "R3", "low select line enables", sdo_en, 1);

        // R11: full-scale codes
        cur_req = "R11";
        start_conv(1'b1, 1'b0, 18'h1FFFF, 1'b1);
        read_bits(DW, '0, w);
        chk(w[17:0] === 18'h1FFFF, "R11", "positive full scale", w[17:0], 18'h1FFFF);
        start_conv(1'b1, 1'b0, 18'h20000, 1'b1);
        read_bits(DW, '0, w);
        chk(w[17:0] === 18'h20000, "R11", "negative full scale", w[17:0], 18'h20000);

        // R8: start bit in select mode
        cur_req = "R8";
        start_conv(1'b1, 1'b1, 18'h3C001, 1'b1);
        read_bits(DW + 1, '0, w);
        chk(w[18:0] === {1'b1, 18'h3C001}, "R8", "start bit then word", w[18:0], {1'b1, 18'h3C001});

        // R7/R2: chain mode forwards upstream data
        cur_req = "R7";
        @(negedge clk); #1 sdi = 1'b0; busy_cfg = 1'b0; sample = 18'h2D2D2; cnv = 1'b1;
        @(negedge clk); #1 cnv = 1'b0;
        @(negedge clk);
        chk(sdo_en === 1'b1, "R2", "chain mode drives in conversion", sdo_en, 1);
        chk(sdo === 1'b0, "R7", "chain drives 0 in conversion", sdo, 0);
        repeat (L) @(negedge clk);
        begin
            logic [39:0] w2;
            w2 = '0;
            read_bits(DW, 18'h1B3C5, w);
            for (int i = 0; i < DW; i++) begin
                w2 = {w2[38:0], sdo};
                fall_once(1'b0);
            end
            chk(w[17:0] === 18'h2D2D2, "R7", "own word first", w[17:0], 18'h2D2D2);
            chk(w2[17:0] === 18'h1B3C5, "R7", "upstream word second", w2[17:0], 18'h1B3C5);
        end

        // R9: chain with start bit waits for upstream
        cur_req = "R9";
        start_conv(1'b0, 1'b1, 18'h0A5A5, 1'b1);
        fall_once(1'b0);
        chk(sdo === 1'b0, "R9", "held low while waiting", sdo, 0);
        chk(sdo_en === 1'b1, "R9", "driving while waiting", sdo_en, 1);
        #1 sdi = 1'b1;
        @(negedge clk); #1 sdi = 1'b0;
        @(negedge clk);
        chk(sdo === 1'b1, "R9", "start bit after upstream done", sdo, 1);
        read_bits(DW + 1, '0, w);
        chk(w[18:0] === {1'b1, 18'h0A5A5}, "R9", "word after ignored fall", w[18:0], {1'b1, 18'h0A5A5});

        repeat (4) @(negedge clk);
        done_flag = 1'b1;
        report();
    end
endmodule